// File: doc/BRIEF.md
# Bit-Time Timestamp and Timeout Counters

This block keeps two 16-bit time bases for a bus protocol controller, both measured in protocol bit times rather than clock cycles. A shared prescaler divides an incoming one-cycle bit-time strobe by a programmable factor of 1 to 16. The resulting tick advances a timestamp counter and a timeout down-counter. The timestamp counter can be held at zero, count prescaled ticks, or mirror an external 16-bit count. Its value is latched on every start-of-frame strobe, for received and transmitted frames alike.

The timeout counter counts down from a programmed period and raises a flag when it lands on zero. It then stays at zero. It runs in one of two ways. In the first it runs freely, and software restarts it by writing to it. In the second it is tied to one of three message FIFOs. While that FIFO is empty the counter is held at the period, and it starts counting once an element has been stored. Software reaches the block through a simple write port. Mode and period writes are accepted only while the controller's init-plus-configuration-enable qualifier is high. Value writes and flag clears are accepted at any time.

Top module: `bt_time_counters`

## Requirements
- R1: After reset, ts_value and ts_capture are 0x0000, to_value is 0xFFFF (the reset period), and wrap_flag and timeout_flag are 0.
- R2: The prescale field P sits at bits 11:8 of the timestamp configuration word (address 0). One tick is produced on every (P+1)-th bit_stb pulse, and that tick moves the counters in the same cycle. An accepted write to address 0 restarts the prescale count.
- R3: The timestamp mode field sits at bits 1:0 of address 0. In mode 0 ts_value is held at 0. In mode 1 ts_value increments by one per tick. In mode 2 ts_value equals ext_count one cycle later. Mode 3 behaves as mode 0.
- R4: In mode 1, a tick that takes ts_value from 0xFFFF to 0x0000 sets wrap_flag.
- R5: Any write to address 1 clears ts_value to 0 in mode 1, and this wins over a tick in the same cycle. In mode 2 the same write has no effect.
- R6: When sof_stb is high, ts_capture takes the ts_value of that same cycle on the next edge.
- R7: When enabled, the timeout counter decrements by one per tick. The tick that takes it from 1 to 0 sets timeout_flag. At 0 it stops.
- R8: The timeout configuration word is address 2: bit 0 enable, bits 5:4 select, bits 31:16 period. With select 0 (continuous), a write to address 3 reloads the period.
- R9: Selects 1, 2 and 3 tie the timeout counter to FIFO index 0, 1 and 2 of fifo_empty and fifo_store. The counter is held at the period until a store on that FIFO is seen. It then counts on ticks while that FIFO's empty input is low. An empty indication without a store re-arms the hold. Stores on other FIFOs have no effect.
- R10: While the enable bit is 0, to_value is held at the period and ticks have no effect.
- R11: Writes to addresses 0 and 2 are ignored while cfg_unlock is low.
- R12: Writing 1 to bit 0 or bit 1 of address 4 clears wrap_flag or timeout_flag respectively. A set event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One-cycle pulse per nominal bit time |
| sof_stb | input | 1 | One-cycle pulse at start of frame (receive or transmit) |
| fifo_empty | input | 3 | Empty indication per FIFO (0 Tx event, 1 Rx FIFO 0, 2 Rx FIFO 1) |
| fifo_store | input | 3 | One-cycle pulse per FIFO when an element is stored |
| ext_count | input | 16 | External timestamp count |
| cfg_unlock | input | 1 | High while init and configuration enable are both set |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 ts config, 1 ts value, 2 timeout config, 3 timeout value, 4 flag clear) |
| wr_data | input | 32 | Register write data |
| ts_value | output | 16 | Live timestamp counter |
| ts_capture | output | 16 | Timestamp latched at the last start of frame |
| to_value | output | 16 | Live timeout counter |
| wrap_flag | output | 1 | Timestamp wraparound interrupt flag |
| timeout_flag | output | 1 | Timeout interrupt flag |

## Verification
The timestamp tick can coincide with a software reset of the counter. A timeout or wrap event can coincide with a write-one-to-clear of its own flag. The bench provokes the first by raising bit_stb in the same cycle as a write to address 1 with the prescaler at its terminal count, and expects ts_value to read 0 afterwards. It provokes the second by clearing timeout_flag in the cycle where the counter steps from 1 to 0, and expects the flag to stay set. A randomized phase then drives strobes, FIFO indications and writes together and compares every output against a cycle model written from the requirements.

// File: rtl/bt_tc_pkg.sv
package bt_tc_pkg;

  localparam int CNT_W_D    = 16;
  localparam int PRE_W_D    = 4;
  localparam int NUM_FIFO_D = 3;
  localparam int ADDR_W_D   = 3;
  localparam int DATA_W_D   = 32;

  // register addresses
  localparam int ADR_TS_CFG = 0;
  localparam int ADR_TS_VAL = 1;
  localparam int ADR_TO_CFG = 2;
  localparam int ADR_TO_VAL = 3;
  localparam int ADR_FLAGS  = 4;

  // field positions
  localparam int TS_MODE_LSB = 0;
  localparam int TS_PRE_LSB  = 8;
  localparam int TO_EN_BIT   = 0;
  localparam int TO_SEL_LSB  = 4;
  localparam int TO_PER_LSB  = 16;
  localparam int FLG_WRAP    = 0;
  localparam int FLG_TOUT    = 1;

  typedef enum logic [1:0] {
    TS_ZERO  = 2'd0,
    TS_COUNT = 2'd1,
    TS_EXT   = 2'd2,
    TS_RSVD  = 2'd3
  } ts_mode_e;

endpackage

// File: rtl/bt_tc_prescale.sv
module bt_tc_prescale #(
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             bit_stb,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q;

  assign tick = bit_stb && (cnt_q >= div);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (bit_stb) begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bt_tc_stamp.sv
module bt_tc_stamp
  import bt_tc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  ts_mode_e         mode,
  input  logic             tick,
  input  logic             zero_wr,
  input  logic [CNT_W-1:0] ext_val,
  input  logic             sof,
  input  logic             clr_flag,
  output logic [CNT_W-1:0] ts_q,
  output logic [CNT_W-1:0] cap_q,
  output logic             wrap_q
);
  logic wrap_ev;

  assign wrap_ev = (mode == TS_COUNT) && !zero_wr && tick && (ts_q == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      ts_q <= '0;
    end else begin
      case (mode)
        TS_COUNT: begin
          if (zero_wr)   ts_q <= '0;
          else if (tick) ts_q <= ts_q + 1'b1;
        end
        TS_EXT:  ts_q <= ext_val;
        default: ts_q <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      if (sof) cap_q <= ts_q;
      wrap_q <= wrap_ev | (wrap_q & ~clr_flag);
    end
  end
endmodule

// File: rtl/bt_tc_timeout.sv
module bt_tc_timeout #(
  parameter int CNT_W    = 16,
  parameter int NUM_FIFO = 3,
  parameter int SEL_W    = $clog2(NUM_FIFO + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [SEL_W-1:0]    sel,
  input  logic [CNT_W-1:0]    period,
  input  logic                tick,
  input  logic                reload_wr,
  input  logic [NUM_FIFO-1:0] fifo_empty,
  input  logic [NUM_FIFO-1:0] fifo_store,
  input  logic                clr_flag,
  output logic [CNT_W-1:0]    to_q,
  output logic                flag_q
);
  logic [NUM_FIFO-1:0] armed_q;
  logic [NUM_FIFO-1:0] hit;
  logic                cont;
  logic                fifo_live;
  logic                hold;
  logic                fire;

  for (genvar k = 0; k < NUM_FIFO; k++) begin : g_fifo
    assign hit[k] = (sel == SEL_W'(k + 1));
    always_ff @(posedge clk) begin
      if (rst)                armed_q[k] <= 1'b0;
      else if (fifo_store[k]) armed_q[k] <= 1'b1;
      else if (fifo_empty[k]) armed_q[k] <= 1'b0;
    end
  end

  always_comb begin
    cont      = (sel == '0);
    fifo_live = |(hit & armed_q & ~fifo_empty);
    hold      = !en || (!cont && !fifo_live) || (cont && reload_wr);
    fire      = !hold && tick && (to_q == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      to_q   <= {CNT_W{1'b1}};
      flag_q <= 1'b0;
    end else begin
      if (hold)                     to_q <= period;
      else if (tick && to_q != '0)  to_q <= to_q - 1'b1;
      flag_q <= fire | (flag_q & ~clr_flag);
    end
  end
endmodule

// File: rtl/bt_time_counters.sv
module bt_time_counters
  import bt_tc_pkg::*;
#(
  parameter int CNT_W    = CNT_W_D,
  parameter int PRE_W    = PRE_W_D,
  parameter int NUM_FIFO = NUM_FIFO_D,
  parameter int ADDR_W   = ADDR_W_D,
  parameter int DATA_W   = DATA_W_D
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_stb,
  input  logic                sof_stb,
  input  logic [NUM_FIFO-1:0] fifo_empty,
  input  logic [NUM_FIFO-1:0] fifo_store,
  input  logic [CNT_W-1:0]    ext_count,
  input  logic                cfg_unlock,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [CNT_W-1:0]    ts_value,
  output logic [CNT_W-1:0]    ts_capture,
  output logic [CNT_W-1:0]    to_value,
  output logic                wrap_flag,
  output logic                timeout_flag
);
  localparam int SEL_W = $clog2(NUM_FIFO + 1);

  ts_mode_e         ts_mode_q;
  logic [PRE_W-1:0] pre_q;
  logic             to_en_q;
  logic [SEL_W-1:0] to_sel_q;
  logic [CNT_W-1:0] to_per_q;

  logic ts_cfg_wr, to_cfg_wr, ts_zero_wr, to_reload_wr, flag_wr;
  logic tick;
  logic unused_bits;

  assign ts_cfg_wr    = wr_en && cfg_unlock && (wr_addr == ADDR_W'(ADR_TS_CFG));
  assign to_cfg_wr    = wr_en && cfg_unlock && (wr_addr == ADDR_W'(ADR_TO_CFG));
  assign ts_zero_wr   = wr_en && (wr_addr == ADDR_W'(ADR_TS_VAL));
  assign to_reload_wr = wr_en && (wr_addr == ADDR_W'(ADR_TO_VAL));
  assign flag_wr      = wr_en && (wr_addr == ADDR_W'(ADR_FLAGS));
  assign unused_bits  = &{wr_data[3:2], wr_data[7:6], wr_data[15:12]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ts_mode_q <= TS_ZERO;
      pre_q     <= '0;
      to_en_q   <= 1'b0;
      to_sel_q  <= '0;
      to_per_q  <= {CNT_W{1'b1}};
    end else begin
      if (ts_cfg_wr) begin
        ts_mode_q <= ts_mode_e'(wr_data[TS_MODE_LSB +: 2]);
        pre_q     <= wr_data[TS_PRE_LSB +: PRE_W];
      end
      if (to_cfg_wr) begin
        to_en_q  <= wr_data[TO_EN_BIT];
        to_sel_q <= wr_data[TO_SEL_LSB +: SEL_W];
        to_per_q <= wr_data[TO_PER_LSB +: CNT_W];
      end
    end
  end

  bt_tc_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .restart (ts_cfg_wr),
    .bit_stb (bit_stb),
    .div     (pre_q),
    .tick    (tick)
  );

  bt_tc_stamp #(.CNT_W(CNT_W)) u_stamp (
    .clk      (clk),
    .rst      (rst),
    .mode     (ts_mode_q),
    .tick     (tick),
    .zero_wr  (ts_zero_wr),
    .ext_val  (ext_count),
    .sof      (sof_stb),
    .clr_flag (flag_wr && wr_data[FLG_WRAP]),
    .ts_q     (ts_value),
    .cap_q    (ts_capture),
    .wrap_q   (wrap_flag)
  );

  bt_tc_timeout #(.CNT_W(CNT_W), .NUM_FIFO(NUM_FIFO), .SEL_W(SEL_W)) u_tout (
    .clk        (clk),
    .rst        (rst),
    .en         (to_en_q),
    .sel        (to_sel_q),
    .period     (to_per_q),
    .tick       (tick),
    .reload_wr  (to_reload_wr),
    .fifo_empty (fifo_empty),
    .fifo_store (fifo_store),
    .clr_flag   (flag_wr && wr_data[FLG_TOUT]),
    .to_q       (to_value),
    .flag_q     (timeout_flag)
  );
endmodule

// File: rtl/bt_tc_checker.sv
module bt_tc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       ts_mode,
  input logic             ts_zero_wr,
  input logic [CNT_W-1:0] ts_value,
  input logic             wrap_flag,
  input logic             wrap_clr,
  input logic [CNT_W-1:0] to_value,
  input logic [CNT_W-1:0] to_period,
  input logic             timeout_flag,
  input logic             cfg_unlock
);
  AST_TS_ZERO_MODE: assert property (@(posedge clk) disable iff (rst)
    (ts_mode == 2'd0) |=> (ts_value == '0)); // R3

  AST_TS_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    (ts_mode == 2'd1 && !ts_zero_wr) |=>
      (ts_value == $past(ts_value) || ts_value == CNT_W'($past(ts_value) + 1'b1))); // R2

  AST_WRAP_FROM_TOP: assert property (@(posedge clk) disable iff (rst)
    $rose(wrap_flag) |-> ($past(ts_value) == {CNT_W{1'b1}})); // R4

  AST_TOUT_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_flag) |-> (to_value == '0)); // R7

  AST_TOUT_NO_JUMP: assert property (@(posedge clk) disable iff (rst)
    (to_value != $past(to_value)) |->
      (to_value == CNT_W'($past(to_value) - 1'b1) || to_value == $past(to_period))); // R7

  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (rst)
    (wrap_flag && !wrap_clr) |=> wrap_flag); // R12

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
    !cfg_unlock |=> $stable(ts_mode)); // R11
endmodule

bind bt_time_counters bt_tc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ts_mode      (ts_mode_q),
  .ts_zero_wr   (ts_zero_wr),
  .ts_value     (ts_value),
  .wrap_flag    (wrap_flag),
  .wrap_clr     (flag_wr && wr_data[0]),
  .to_value     (to_value),
  .to_period    (to_per_q),
  .timeout_flag (timeout_flag),
  .cfg_unlock   (cfg_unlock)
);

// File: tb/bt_time_counters_bench.sv
`timescale 1ns/1ps
module bt_time_counters_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_stb = 1'b0, sof_stb = 1'b0;
  logic [2:0]  fifo_empty = 3'b111, fifo_store = 3'b000;
  logic [15:0] ext_count = 16'h0;
  logic        cfg_unlock = 1'b0, wr_en = 1'b0;
  logic [2:0]  wr_addr = 3'd0;
  logic [31:0] wr_data = 32'h0;
  logic [15:0] ts_value, ts_capture, to_value;
  logic        wrap_flag, timeout_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bt_time_counters u_bt_time_counters (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .sof_stb(sof_stb),
    .fifo_empty(fifo_empty), .fifo_store(fifo_store), .ext_count(ext_count),
    .cfg_unlock(cfg_unlock), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ts_value(ts_value), .ts_capture(ts_capture), .to_value(to_value),
    .wrap_flag(wrap_flag), .timeout_flag(timeout_flag)
  );

  // reference state, written from the requirements
  logic [15:0] m_ts, m_cap, m_to, m_per;
  logic        m_wrap, m_tof, m_en;
  logic [1:0]  m_mode, m_sel;
  logic [3:0]  m_pre, m_pcnt;
  logic [2:0]  m_armed;

  task automatic model_reset();
    m_ts = 0; m_cap = 0; m_to = 16'hFFFF; m_per = 16'hFFFF;
    m_wrap = 0; m_tof = 0; m_en = 0; m_mode = 0; m_sel = 0;
    m_pre = 0; m_pcnt = 0; m_armed = 0;
  endtask

  task automatic model_update();
    logic tick, cfg0, cfg2, wr1, wr3, clrw, clrt, live, hold, wev, tev;
    logic [15:0] ts_n, to_n;
    cfg0 = wr_en && cfg_unlock && wr_addr == 3'd0;
    cfg2 = wr_en && cfg_unlock && wr_addr == 3'd2;
    wr1  = wr_en && wr_addr == 3'd1;
    wr3  = wr_en && wr_addr == 3'd3;
    clrw = wr_en && wr_addr == 3'd4 && wr_data[0];
    clrt = wr_en && wr_addr == 3'd4 && wr_data[1];
    tick = bit_stb && (m_pcnt >= m_pre);
    // timestamp (R3, R4, R5)
    wev = 0; ts_n = 0;
    if (m_mode == 2'd1) begin
      if (wr1) ts_n = 0;
      else if (tick) begin ts_n = m_ts + 16'd1; wev = (m_ts == 16'hFFFF); end
      else ts_n = m_ts;
    end else if (m_mode == 2'd2) ts_n = ext_count;
    // timeout (R7..R10)
    live = (m_sel != 0) && m_armed[m_sel - 2'd1] && !fifo_empty[m_sel - 2'd1];
    hold = !m_en || (m_sel != 0 && !live) || (m_sel == 0 && wr3);
    tev = !hold && tick && (m_to == 16'd1);
    if (hold) to_n = m_per;
    else if (tick && m_to != 0) to_n = m_to - 16'd1;
    else to_n = m_to;
    if (sof_stb) m_cap = m_ts;
    m_ts = ts_n; m_to = to_n;
    m_wrap = wev | (m_wrap & ~clrw);
    m_tof  = tev | (m_tof & ~clrt);
    for (int k = 0; k < 3; k++)
      if (fifo_store[k]) m_armed[k] = 1; else if (fifo_empty[k]) m_armed[k] = 0;
    if (cfg0) m_pcnt = 0; else if (bit_stb) m_pcnt = tick ? 4'd0 : m_pcnt + 4'd1;
    if (cfg0) begin m_mode = wr_data[1:0]; m_pre = wr_data[11:8]; end
    if (cfg2) begin m_en = wr_data[0]; m_sel = wr_data[5:4]; m_per = wr_data[31:16]; end
  endtask

  task automatic step();
    @(posedge clk);
    if (rst) model_reset(); else model_update();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    step();
    wr_en = 0;
  endtask

  task automatic ticks(input int n);
    bit_stb = 1;
    for (int i = 0; i < n; i++) step();
    bit_stb = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) step();
    rst = 0;
    step();
    // R1 reset state
    chk("R1 ts_value", ts_value, 0);
    chk("R1 ts_capture", ts_capture, 0);
    chk("R1 to_value", to_value, 16'hFFFF);
    chk("R1 flags", {wrap_flag, timeout_flag}, 0);

    // R2 divide by 3
    cfg_unlock = 1;
    wr(3'd0, 32'h0000_0201);
    ticks(6);
    chk("R2 after 6 strobes", ts_value, 2);
    ticks(2);
    chk("R2 partial period", ts_value, 2);
    ticks(1);
    chk("R2 third period", ts_value, 3);

    // R11 locked config write ignored
    cfg_unlock = 0;
    wr(3'd0, 32'h0000_0000);
    ticks(3);
    chk("R11 locked ts config", ts_value, 4);
    cfg_unlock = 1;

    // R5 zeroing write beats a tick
    wr(3'd0, 32'h0000_0001);
    ticks(2);
    bit_stb = 1; wr_en = 1; wr_addr = 3'd1; wr_data = 0;
    step();
    wr_en = 0; bit_stb = 0;
    chk("R5 write beats tick", ts_value, 0);

    // R6 capture at start of frame
    ticks(5);
    sof_stb = 1; bit_stb = 1;
    step();
    sof_stb = 0; bit_stb = 0;
    chk("R6 capture value", ts_capture, 5);
    chk("R6 counter moved on", ts_value, 6);

    // R4 wraparound
    wr(3'd1, 0);
    ticks(65535);
    chk("R4 at top", {wrap_flag, ts_value}, {1'b0, 16'hFFFF});
    ticks(1);
    chk("R4 wrapped", {wrap_flag, ts_value}, {1'b1, 16'h0000});
    wr(3'd4, 32'h1);
    chk("R12 wrap cleared", wrap_flag, 0);

    // R3 external and reserved modes, R5 write ignored in external mode
    wr(3'd0, 32'h0000_0002);
    ext_count = 16'hA5C3;
    step();
    chk("R3 external", ts_value, 16'hA5C3);
    wr(3'd1, 0);
    chk("R5 write ignored in external mode", ts_value, 16'hA5C3);
    wr(3'd0, 32'h0000_0003);
    step();
    chk("R3 reserved mode holds zero", ts_value, 0);
    wr(3'd0, 32'h0000_0000);
    ticks(4);
    chk("R3 mode 0 holds zero", ts_value, 0);

    // R10 disabled timeout holds period
    wr(3'd0, 32'h0000_0001);
    wr(3'd2, 32'h0005_0000);
    ticks(3);
    chk("R10 disabled holds period", to_value, 5);
    // R7 continuous countdown
    wr(3'd2, 32'h0005_0001);
    ticks(4);
    chk("R7 count to 1", {timeout_flag, to_value}, {1'b0, 16'd1});
    ticks(1);
    chk("R7 reaches zero", {timeout_flag, to_value}, {1'b1, 16'd0});
    ticks(3);
    chk("R7 stops at zero", to_value, 0);
    wr(3'd3, 0);
    chk("R8 reload", to_value, 5);
    // R12 set wins over clear
    ticks(4);
    bit_stb = 1; wr_en = 1; wr_addr = 3'd4; wr_data = 32'h2;
    step();
    bit_stb = 0; wr_en = 0;
    chk("R12 set wins", {timeout_flag, to_value}, {1'b1, 16'd0});
    wr(3'd4, 32'h2);
    chk("R12 timeout cleared", timeout_flag, 0);

    // R9 FIFO-driven timeout, select 2 -> FIFO index 1
    wr(3'd2, 32'h0003_0021);
    ticks(4);
    chk("R9 held while empty", to_value, 3);
    fifo_store = 3'b001; fifo_empty = 3'b110;
    step();
    fifo_store = 0;
    ticks(2);
    chk("R9 other FIFO ignored", to_value, 3);
    fifo_store = 3'b010; fifo_empty = 3'b100;
    step();
    fifo_store = 0;
    ticks(2);
    chk("R9 counting after store", to_value, 1);
    fifo_empty = 3'b110;
    step();
    chk("R9 reload on empty", to_value, 3);
    ticks(2);
    chk("R9 hold after empty", to_value, 3);

    // randomized phase against the reference
    void'($urandom(32'h5EED_0042));
    for (int c = 0; c < 3000; c++) begin
      bit_stb    = ($urandom % 3) == 0;
      sof_stb    = ($urandom % 16) == 0;
      fifo_store = 3'($urandom % 8) & 3'($urandom % 8);
      fifo_empty = 3'($urandom % 8);
      ext_count  = 16'($urandom);
      cfg_unlock = $urandom % 2;
      wr_en      = ($urandom % 8) == 0;
      wr_addr    = 3'($urandom % 5);
      wr_data    = $urandom;
      if (wr_addr == 3'd2) wr_data = {16'($urandom % 20), 10'd0, 2'($urandom), 3'd0, 1'($urandom % 4 != 0)};
      if (wr_addr == 3'd0) wr_data = {20'd0, 4'($urandom), 6'd0, 2'($urandom)};
      step();
      chk("R3 random ts_value", ts_value, m_ts);
      chk("R6 random ts_capture", ts_capture, m_cap);
      chk("R9 random to_value", to_value, m_to);
      chk("R4 random wrap_flag", wrap_flag, m_wrap);
      chk("R7 random timeout_flag", timeout_flag, m_tof);
    end
    wr_en = 0; bit_stb = 0; sof_stb = 0;
    done = 1;
    finish_run();
  end
endmodule